// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block watches a single-request load/store port between a compute unit and a memory-side buffer. The port does not work fire-and-forget. Once a load or a store is requested, the port's busy flag must stay high until completion is guaranteed. Busy then drops at a time that depends on how the request ends. For a load it drops with the single-cycle load-data pulse. For a store it drops one cycle after the single-cycle store-data pulse. For a failed request it drops with the exception pulse. The monitor only observes the port. It drives nothing onto the port and holds no memory image.

The monitor follows each transaction with a small phase tracker. It tests the port against nine ordering rules in every cycle. The first breach after reset is stored as a 4-bit code, together with a sticky flag, and both stay set until reset. A kill input aborts the transaction being tracked without clearing a stored error. Two counters report completed loads and completed stores, so a test environment can see which kinds of transaction it has exercised.

Top module: `lsport_monitor`

## Requirements
- R1: A cycle in which the load request and the store request are both high is a breach with code 1.
- R2: A rising edge of either request while a transaction is still tracked (loading, storing or draining) is a breach with code 2.
- R3: During a load or store, including the cycle the request first rises, busy low is a breach with code 3 unless an exception pulse or, for a load past its first cycle, a load-data pulse is present in that cycle.
- R4: Once the address valid flag has been seen in a transaction, a later cycle with busy high in which the address valid flag is low or the address differs from the captured value is a breach with code 4.
- R5: An address acknowledge outside a load or store, or a second acknowledge in one transaction, is a breach with code 5.
- R6: An exception pulse outside a load or store, or an exception pulse with busy still high, is a breach with code 6.
- R7: A load-data pulse is a breach with code 7 when no load is tracked from an earlier cycle, when busy is still high, or when no address acknowledge came in an earlier cycle.
- R8: A store-data pulse is a breach with code 8 when no store is tracked from an earlier cycle or when no address acknowledge came in an earlier cycle. A second consecutive pulse falls into this case.
- R9: Busy still high in the cycle after an accepted store-data pulse is a breach with code 9.
- R10: Kill returns the tracker to idle in the next cycle and clears the captured acknowledge and address. No rule is evaluated in a kill cycle. A stored error is kept.
- R11: The error code is 0 with the flag low after reset. The code of the first breach appears one cycle after it. When several rules break in one cycle, the lowest code is stored. The code then holds until reset.
- R12: The load counter increments once per load-data pulse on a tracked load. The store counter increments once per completed store drain cycle. Exceptions and kills are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kill | input | 1 | Abort of the tracked transaction |
| ld_req | input | 1 | Load request level |
| st_req | input | 1 | Store request level |
| busy | input | 1 | Port busy flag |
| addr_vld | input | 1 | Address valid flag |
| addr | input | AW | Request address |
| addr_ack | input | 1 | Address acknowledge pulse |
| exc | input | 1 | Exception pulse |
| ld_vld | input | 1 | Load-data valid pulse |
| st_vld | input | 1 | Store-data valid pulse |
| err_flag | output | 1 | Sticky breach flag |
| err_code | output | 4 | First breach code, 0 when none |
| ld_cnt | output | CW | Completed loads |
| st_cnt | output | CW | Completed stores |

## Verification
The hardest situations to reach from the ports are those whose legality depends on a one-cycle offset: busy dropping in the store-data cycle instead of one cycle later, and a load-data or store-data pulse in the same cycle as the acknowledge instead of after it. The bench reaches them with short scripted sequences that shift one edge by one cycle relative to a legal transaction. It also sweeps every combination of latency and acknowledge position up to four cycles for both loads and stores, back to back. Kill is exercised in the middle of a load, followed at once by a store that would break two rules if the abort had not cleared the tracker.

// File: rtl/lsmon_pkg.sv
package lsmon_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_STORE = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;

  localparam int NRULES = 9;

  localparam logic [3:0] C_NONE      = 4'd0;
  localparam logic [3:0] C_BOTH_REQ  = 4'd1;
  localparam logic [3:0] C_REQ_BUSY  = 4'd2;
  localparam logic [3:0] C_BUSY_LOW  = 4'd3;
  localparam logic [3:0] C_ADDR_MOVE = 4'd4;
  localparam logic [3:0] C_ACK_BAD   = 4'd5;
  localparam logic [3:0] C_EXC_BAD   = 4'd6;
  localparam logic [3:0] C_LDV_BAD   = 4'd7;
  localparam logic [3:0] C_STV_BAD   = 4'd8;
  localparam logic [3:0] C_ST_LATE   = 4'd9;

  function automatic logic in_flight(input phase_e p);
    return (p == PH_LOAD) || (p == PH_STORE);
  endfunction

  // bit i of hits stands for code i+1; lowest code wins
  function automatic logic [3:0] first_code(input logic [NRULES-1:0] hits);
    logic [3:0] r;
    r = C_NONE;
    for (int i = NRULES - 1; i >= 0; i--) begin
      if (hits[i]) r = 4'(i + 1);
    end
    return r;
  endfunction

  function automatic phase_e next_phase(input phase_e cur, input logic start,
                                        input logic busy, input logic exc,
                                        input logic ld_vld, input logic st_vld);
    phase_e n;
    n = PH_IDLE;
    case (cur)
      PH_LOAD: begin
        if (exc || !busy || (ld_vld && !start)) n = PH_IDLE;
        else n = PH_LOAD;
      end
      PH_STORE: begin
        if (exc || !busy) n = PH_IDLE;
        else if (st_vld && !start) n = PH_DRAIN;
        else n = PH_STORE;
      end
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/lsmon_tracker.sv
module lsmon_tracker
  import lsmon_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          ld_req,
  input  logic          st_req,
  input  logic          busy,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          addr_ack,
  input  logic          exc,
  input  logic          ld_vld,
  input  logic          st_vld,
  output phase_e        phase,
  output phase_e        cur,
  output logic          start,
  output logic          req_edge,
  output logic          ack_seen,
  output logic          addr_held,
  output logic [AW-1:0] addr_q,
  output logic          ld_done,
  output logic          st_done
);

  logic   ld_q, st_q;
  phase_e nxt;
  logic   cur_active;

  assign req_edge   = (ld_req && !ld_q) || (st_req && !st_q);
  assign start      = req_edge && (phase == PH_IDLE);
  assign cur        = start ? (ld_req ? PH_LOAD : PH_STORE) : phase;
  assign cur_active = in_flight(cur);
  assign nxt        = next_phase(cur, start, busy, exc, ld_vld, st_vld);

  assign ld_done = !kill && (phase == PH_LOAD) && ld_vld;
  assign st_done = !kill && (phase == PH_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q      <= 1'b0;
      st_q      <= 1'b0;
      phase     <= PH_IDLE;
      ack_seen  <= 1'b0;
      addr_held <= 1'b0;
      addr_q    <= '0;
    end else begin
      ld_q <= ld_req;
      st_q <= st_req;
      if (kill) begin
        phase     <= PH_IDLE;
        ack_seen  <= 1'b0;
        addr_held <= 1'b0;
      end else begin
        phase     <= nxt;
        ack_seen  <= in_flight(nxt) && (ack_seen || (addr_ack && cur_active));
        addr_held <= in_flight(nxt) && (addr_held || (addr_vld && cur_active));
        if (addr_vld && cur_active && !addr_held) addr_q <= addr;
      end
    end
  end

endmodule

// File: rtl/lsmon_rules.sv
module lsmon_rules
  import lsmon_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic          kill,
  input  logic          ld_req,
  input  logic          st_req,
  input  logic          busy,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          addr_ack,
  input  logic          exc,
  input  logic          ld_vld,
  input  logic          st_vld,
  input  phase_e        phase,
  input  phase_e        cur,
  input  logic          req_edge,
  input  logic          ack_seen,
  input  logic          addr_held,
  input  logic [AW-1:0] addr_q,
  output logic [3:0]    viol_code
);

  logic [NRULES-1:0] hits;
  logic              act;
  logic              ld_finish;

  assign act       = in_flight(cur);
  assign ld_finish = (phase == PH_LOAD) && ld_vld;

  always_comb begin
    hits    = '0;
    hits[0] = ld_req && st_req;
    hits[1] = req_edge && (phase != PH_IDLE);
    hits[2] = act && !busy && !exc && !ld_finish;
    hits[3] = in_flight(phase) && busy && addr_held &&
              (!addr_vld || (addr != addr_q));
    hits[4] = addr_ack && (!act || ack_seen);
    hits[5] = exc && (!act || busy);
    hits[6] = ld_vld && ((phase != PH_LOAD) || busy || !ack_seen);
    hits[7] = st_vld && ((phase != PH_STORE) || !ack_seen);
    hits[8] = (phase == PH_DRAIN) && busy;
    if (kill) hits = '0;
  end

  assign viol_code = first_code(hits);

endmodule

// File: rtl/lsmon_log.sv
module lsmon_log #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    viol_code,
  input  logic          ld_done,
  input  logic          st_done,
  output logic [3:0]    err_code,
  output logic [CW-1:0] ld_cnt,
  output logic [CW-1:0] st_cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_code <= 4'd0;
      ld_cnt   <= '0;
      st_cnt   <= '0;
    end else begin
      if ((err_code == 4'd0) && (viol_code != 4'd0)) err_code <= viol_code;
      if (ld_done) ld_cnt <= ld_cnt + 1'b1;
      if (st_done) st_cnt <= st_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lsport_monitor.sv
module lsport_monitor
  import lsmon_pkg::*;
#(
  parameter int AW = 48,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          ld_req,
  input  logic          st_req,
  input  logic          busy,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          addr_ack,
  input  logic          exc,
  input  logic          ld_vld,
  input  logic          st_vld,
  output logic          err_flag,
  output logic [3:0]    err_code,
  output logic [CW-1:0] ld_cnt,
  output logic [CW-1:0] st_cnt
);

  phase_e        phase, cur;
  logic          start, req_edge, ack_seen, addr_held;
  logic [AW-1:0] addr_q;
  logic          ld_done, st_done;
  logic [3:0]    viol_code;
  logic          trk_idle;

  lsmon_tracker #(.AW(AW)) u_trk (
    .clk(clk), .rst_n(rst_n), .kill(kill), .ld_req(ld_req), .st_req(st_req),
    .busy(busy), .addr_vld(addr_vld), .addr(addr), .addr_ack(addr_ack),
    .exc(exc), .ld_vld(ld_vld), .st_vld(st_vld), .phase(phase), .cur(cur),
    .start(start), .req_edge(req_edge), .ack_seen(ack_seen),
    .addr_held(addr_held), .addr_q(addr_q), .ld_done(ld_done), .st_done(st_done)
  );

  lsmon_rules #(.AW(AW)) u_rules (
    .kill(kill), .ld_req(ld_req), .st_req(st_req), .busy(busy),
    .addr_vld(addr_vld), .addr(addr), .addr_ack(addr_ack), .exc(exc),
    .ld_vld(ld_vld), .st_vld(st_vld), .phase(phase), .cur(cur),
    .req_edge(req_edge), .ack_seen(ack_seen), .addr_held(addr_held),
    .addr_q(addr_q), .viol_code(viol_code)
  );

  lsmon_log #(.CW(CW)) u_log (
    .clk(clk), .rst_n(rst_n), .viol_code(viol_code), .ld_done(ld_done),
    .st_done(st_done), .err_code(err_code), .ld_cnt(ld_cnt), .st_cnt(st_cnt)
  );

  assign err_flag = (err_code != 4'd0);
  assign trk_idle = (phase == PH_IDLE);

endmodule

// File: rtl/lsmon_checker.sv
module lsmon_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          kill,
  input logic          ld_req,
  input logic          st_req,
  input logic          ld_vld,
  input logic          err_flag,
  input logic [3:0]    err_code,
  input logic [3:0]    viol_code,
  input logic [CW-1:0] ld_cnt,
  input logic [CW-1:0] st_cnt,
  input logic          trk_idle,
  input logic          st_done
);

  assert_first_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_code != 4'd0 && err_code == 4'd0) |=> err_code == $past(viol_code));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 4'd0) |=> $stable(err_code));

  assert_flag_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(viol_code) != 4'd0);

  assert_both_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && st_req && !kill && err_code == 4'd0) |=> err_code == 4'd1);

  assert_kill_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> trk_idle);

  assert_ld_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cnt != $past(ld_cnt)) |-> $past(ld_vld && !kill));

  assert_st_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cnt != $past(st_cnt)) |-> $past(st_done));

endmodule

bind lsport_monitor lsmon_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .kill(kill), .ld_req(ld_req), .st_req(st_req),
  .ld_vld(ld_vld), .err_flag(err_flag), .err_code(err_code),
  .viol_code(viol_code), .ld_cnt(ld_cnt), .st_cnt(st_cnt),
  .trk_idle(trk_idle), .st_done(st_done)
);

// File: tb/lsport_monitor_test.sv
`timescale 1ns/1ps
module lsport_monitor_test;

  localparam int AW = 48;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          kill = 1'b0, ld_req = 1'b0, st_req = 1'b0, busy = 1'b0;
  logic          addr_vld = 1'b0, addr_ack = 1'b0, exc = 1'b0;
  logic          ld_vld = 1'b0, st_vld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          err_flag;
  logic [3:0]    err_code;
  logic [CW-1:0] ld_cnt, st_cnt;

  int checks = 0;
  int errors = 0;
  int exp_ld = 0;
  int exp_st = 0;

  always #4 clk = ~clk;

  lsport_monitor #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .kill(kill), .ld_req(ld_req), .st_req(st_req),
    .busy(busy), .addr_vld(addr_vld), .addr(addr), .addr_ack(addr_ack),
    .exc(exc), .ld_vld(ld_vld), .st_vld(st_vld), .err_flag(err_flag),
    .err_code(err_code), .ld_cnt(ld_cnt), .st_cnt(st_cnt)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic l, input logic s, input logic b,
                       input logic av, input logic [AW-1:0] a, input logic ak,
                       input logic ex, input logic lv, input logic sv,
                       input logic kl);
    ld_req = l; st_req = s; busy = b; addr_vld = av; addr = a;
    addr_ack = ak; exc = ex; ld_vld = lv; st_vld = sv; kill = kl;
    tick();
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    ld_req = 0; st_req = 0; busy = 0; addr_vld = 0; addr = '0;
    addr_ack = 0; exc = 0; ld_vld = 0; st_vld = 0; kill = 0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    exp_ld = 0;
    exp_st = 0;
  endtask

  task automatic run_load(input int lat, input int ackpos, input logic [AW-1:0] a);
    for (int c = 0; c <= lat; c++) drive(1, 0, 1, 1, a, c == ackpos, 0, 0, 0, 0);
    drive(0, 0, 0, 1, a, 0, 0, 1, 0, 0);
    idle();
    exp_ld++;
  endtask

  task automatic run_store(input int lat, input int ackpos, input logic [AW-1:0] a);
    for (int c = 0; c <= lat; c++) drive(0, 1, 1, 1, a, c == ackpos, 0, 0, 0, 0);
    drive(0, 0, 1, 1, a, 0, 0, 0, 1, 0);
    idle();
    exp_st++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick();
    chk("R11 code in reset", err_code, 0);
    chk("R11 flag in reset", err_flag, 0);
    chk("R12 ld count in reset", ld_cnt, 0);
    chk("R12 st count in reset", st_cnt, 0);
    do_reset();

    // sweep of legal loads and stores: latency 0..3, ack position 0..lat
    for (int lat = 0; lat < 4; lat++) begin
      for (int ap = 0; ap <= lat; ap++) begin
        run_load(lat, ap, 48'h1000 + 48'(lat * 16 + ap));
        chk("R12 ld count after load", ld_cnt, exp_ld);
        chk("R7 legal load code", err_code, 0);
        run_store(lat, ap, 48'h2000 + 48'(lat * 16 + ap));
        chk("R12 st count after store", st_cnt, exp_st);
        chk("R9 legal store code", err_code, 0);
      end
    end
    chk("R12 ld total", ld_cnt, 10);
    chk("R12 st total", st_cnt, 10);

    // legal exception ends a load without counting (R6, R12)
    drive(1, 0, 1, 1, 48'h77, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 48'h77, 0, 1, 0, 0, 0);
    idle();
    chk("R6 legal exception code", err_code, 0);
    chk("R12 exception not counted", ld_cnt, exp_ld);

    // R1 both requests
    do_reset();
    drive(1, 1, 1, 1, 48'h5, 0, 0, 0, 0, 0);
    idle();
    chk("R1 both requests", err_code, 1);
    chk("R11 flag set", err_flag, 1);

    // R2 new request while busy
    do_reset();
    drive(1, 0, 1, 1, 48'h5, 1, 0, 0, 0, 0);
    drive(0, 1, 1, 1, 48'h5, 0, 0, 0, 0, 0);
    idle();
    chk("R2 request while busy", err_code, 2);

    // R2 request during drain cycle
    do_reset();
    drive(0, 1, 1, 1, 48'h9, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 1, 48'h9, 0, 0, 0, 1, 0);
    drive(1, 0, 0, 1, 48'h9, 0, 0, 0, 0, 0);
    idle();
    chk("R2 request in drain", err_code, 2);

    // R3 busy not raised with request
    do_reset();
    drive(1, 0, 0, 1, 48'h5, 0, 0, 0, 0, 0);
    idle();
    chk("R3 busy missing at start", err_code, 3);

    // R3 busy falls in the store-data cycle (one cycle early)
    do_reset();
    drive(0, 1, 1, 1, 48'h5, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 48'h5, 0, 0, 0, 1, 0);
    idle();
    chk("R3 store busy early", err_code, 3);

    // R4 address changes
    do_reset();
    drive(1, 0, 1, 1, 48'h40, 1, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 48'h41, 0, 0, 0, 0, 0);
    idle();
    chk("R4 address moved", err_code, 4);

    // R4 address valid dropped
    do_reset();
    drive(0, 1, 1, 1, 48'h40, 0, 0, 0, 0, 0);
    drive(0, 1, 1, 0, 48'h40, 0, 0, 0, 0, 0);
    idle();
    chk("R4 address valid dropped", err_code, 4);

    // R5 double acknowledge
    do_reset();
    drive(1, 0, 1, 1, 48'h8, 1, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 48'h8, 1, 0, 0, 0, 0);
    idle();
    chk("R5 second ack", err_code, 5);

    // R5 ack when idle
    do_reset();
    drive(0, 0, 0, 0, '0, 1, 0, 0, 0, 0);
    idle();
    chk("R5 ack while idle", err_code, 5);

    // R5 and R6 together: lowest code wins (R11)
    do_reset();
    drive(1, 0, 1, 1, 48'h8, 1, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 48'h8, 1, 1, 0, 0, 0);
    idle();
    chk("R11 priority of ack over exception", err_code, 5);

    // R6 exception with busy high
    do_reset();
    drive(1, 0, 1, 1, 48'h8, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 48'h8, 0, 1, 0, 0, 0);
    idle();
    chk("R6 exception busy high", err_code, 6);

    // R7 load data with busy high
    do_reset();
    drive(1, 0, 1, 1, 48'h8, 1, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 48'h8, 0, 0, 1, 0, 0);
    idle();
    chk("R7 load data busy high", err_code, 7);

    // R7 load data in the ack cycle
    do_reset();
    drive(1, 0, 1, 1, 48'h8, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 48'h8, 1, 0, 1, 0, 0);
    idle();
    chk("R7 load data with ack", err_code, 7);

    // R8 store data in the ack cycle
    do_reset();
    drive(0, 1, 1, 1, 48'h8, 0, 0, 0, 0, 0);
    drive(0, 1, 1, 1, 48'h8, 1, 0, 0, 1, 0);
    idle();
    chk("R8 store data with ack", err_code, 8);

    // R8 store data pulse two cycles
    do_reset();
    drive(0, 1, 1, 1, 48'h8, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 1, 48'h8, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 1, 48'h8, 0, 0, 0, 1, 0);
    idle();
    chk("R8 store data twice", err_code, 8);

    // R9 busy late after store data
    do_reset();
    drive(0, 1, 1, 1, 48'h8, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 1, 48'h8, 0, 0, 0, 1, 0);
    drive(0, 0, 1, 1, 48'h8, 0, 0, 0, 0, 0);
    idle();
    chk("R9 busy late", err_code, 9);

    // R10 kill mid-load, then an immediate store with its own ack
    do_reset();
    drive(1, 0, 1, 1, 48'h30, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 48'h0, 0, 0, 0, 0, 1);
    drive(0, 1, 1, 1, 48'h31, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 1, 48'h31, 0, 0, 0, 1, 0);
    idle();
    chk("R10 no error after kill", err_code, 0);
    chk("R10 store counted after kill", st_cnt, 1);
    chk("R10 killed load not counted", ld_cnt, 0);

    // R10 kill keeps a stored error; R11 sticky first code
    do_reset();
    drive(1, 1, 0, 0, '0, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 48'h2, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 0, '0, 0, 0, 0, 0, 1);
    idle();
    chk("R11 first code kept", err_code, 1);
    chk("R10 kill keeps error flag", err_flag, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule